// File: doc/BRIEF.md
# Strided Tensor Lane Address Sequencer

This block generates the address stream for one pass over a four-dimensional tensor (outer to inner: batch, channel, row, column) held in a memory split into parallel lanes. Each lane owns a private slice of local memory. Channels are dealt out to lanes in rotation, beginning at a chosen start lane. Channels that fall into the same lane are stacked in slots, and the channel stride is the distance between two neighbouring slots of one lane. For every element the sequencer gives the lane number, the byte address inside that lane's slice, the four indices, and the byte address the same element would have in a densely packed copy in global memory.

Software-side logic or a DMA engine loads the shape, the four strides (counted in elements), the start lane, the element size and a byte base, and then pulses start. The sequencer then offers one element per cycle under a valid/ready handshake and pulses done once the walk is over. It also reports how many channel slots each lane needs. A sticky flag records any element whose lane address went past the end of the slice.

Top module: `tensor_lane_walker`

## Requirements
- R1: After reset, out_valid, done, busy and ovf_err are all 0.
- R2: Elements come out in this order: column index fastest, then row, then channel, then batch, all starting at (0,0,0,0). Each dimension wraps to 0 when it passes its extent minus one.
- R3: Channel c goes to lane (start_lane + c) mod LANES, in slot floor((start_lane + c) / LANES).
- R4: out_laddr is (base_ofs + (n*str_n + slot*str_c + h*str_h + w*str_w) * size) mod LANE_BYTES. size is set by elem_size: 0 gives 1 byte, 1 gives 2 bytes, 2 or 3 gives 4 bytes.
- R5: out_gaddr is (((n*C + c)*H + h)*W + w) * size, which is the densely packed global layout.
- R6: An element moves across only when out_valid and out_ready are both 1. While out_valid is 1 and out_ready is 0, every output holds its value into the next cycle.
- R7: Exactly N*C*H*W elements cross. done is 1 for the single cycle after the last transfer, and out_valid is 0 in that cycle.
- R8: A start with any extent equal to zero produces no elements, and done is 1 in the next cycle.
- R9: ovf_err goes to 1 in the cycle after a transfer whose unwrapped lane address is LANE_BYTES or more. That element is still emitted. The flag stays at 1 until the next accepted start clears it.
- R10: chans_per_lane equals ceil((start_lane + C) / LANES) for the last accepted start.
- R11: A start pulse while busy is 1 is ignored, and the walk in progress continues with its original configuration.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Accept configuration and begin a walk |
| shp_n | input | DIM_W | Batch extent |
| shp_c | input | DIM_W | Channel extent |
| shp_h | input | DIM_W | Row extent |
| shp_w | input | DIM_W | Column extent |
| start_lane | input | LANE_LOG | Lane holding channel 0 |
| str_n | input | STR_W | Batch stride in elements |
| str_c | input | STR_W | Same-lane slot stride in elements |
| str_h | input | STR_W | Row stride in elements |
| str_w | input | STR_W | Column stride in elements |
| elem_size | input | 2 | Element size code |
| base_ofs | input | LADDR_W | Byte base inside every lane slice |
| out_ready | input | 1 | Consumer accepts the element |
| out_valid | output | 1 | Element offered |
| out_lane | output | LANE_LOG | Target lane |
| out_laddr | output | LADDR_W | Byte address within lane slice |
| out_gaddr | output | 4*DIM_W+2 | Byte address in packed global layout |
| out_n | output | DIM_W | Batch index |
| out_c | output | DIM_W | Channel index |
| out_h | output | DIM_W | Row index |
| out_w | output | DIM_W | Column index |
| chans_per_lane | output | DIM_W+1 | Slots needed per lane |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Walk finished pulse |
| ovf_err | output | 1 | Sticky lane slice overflow |

## Verification
Every address is computed directly from the index registers, so a bad counter step or a bad wrap shows up as a wrong index or address on the very transfer that follows it. A bad lane or slot split shows as a wrong lane number or lane address at the first channel that wraps past the last lane. A terminal-condition fault shows one cycle after the last transfer, either as done arriving early or late or as an element count that differs from N*C*H*W. A stall fault shows in the cycle after out_ready is withheld, as an output that changed while it should have held. A fault in the overflow latch shows when the flag is read after done.

// File: rtl/tlw_pkg.sv
package tlw_pkg;

    localparam int unsigned DIM_W = 8;
    localparam int unsigned STR_W = 16;

    typedef logic [DIM_W-1:0] dim_t;
    typedef logic [STR_W-1:0] str_t;

    localparam dim_t DIM_ONE = dim_t'(1);

    typedef enum logic [1:0] {
        ESZ_BYTE  = 2'd0,
        ESZ_HALF  = 2'd1,
        ESZ_WORD  = 2'd2,
        ESZ_WORDX = 2'd3
    } esz_e;

    typedef struct packed {
        dim_t n;
        dim_t c;
        dim_t h;
        dim_t w;
    } idx_t;

    typedef struct packed {
        str_t n;
        str_t c;
        str_t h;
        str_t w;
    } stride_t;

    function automatic logic [1:0] esz_shift(input esz_e e);
        case (e)
            ESZ_BYTE: return 2'd0;
            ESZ_HALF: return 2'd1;
            default:  return 2'd2;
        endcase
    endfunction

    function automatic logic any_zero(input idx_t s);
        return (s.n == '0) || (s.c == '0) || (s.h == '0) || (s.w == '0);
    endfunction

endpackage

// File: rtl/tlw_walker.sv
module tlw_walker
    import tlw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic launch,
    input  logic advance,
    input  idx_t shape_in,
    output idx_t idx,
    output idx_t shape_q,
    output logic active,
    output logic finished
);

    logic end_w, end_h, end_c, end_n;
    idx_t idx_nx;

    always_comb begin
        end_w = (idx.w == shape_q.w - DIM_ONE);
        end_h = (idx.h == shape_q.h - DIM_ONE);
        end_c = (idx.c == shape_q.c - DIM_ONE);
        end_n = (idx.n == shape_q.n - DIM_ONE);
        idx_nx = idx;
        if (!end_w) begin
            idx_nx.w = idx.w + DIM_ONE;
        end else begin
            idx_nx.w = '0;
            if (!end_h) begin
                idx_nx.h = idx.h + DIM_ONE;
            end else begin
                idx_nx.h = '0;
                if (!end_c) begin
                    idx_nx.c = idx.c + DIM_ONE;
                end else begin
                    idx_nx.c = '0;
                    idx_nx.n = idx.n + DIM_ONE;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx      <= '0;
            shape_q  <= '0;
            active   <= 1'b0;
            finished <= 1'b0;
        end else begin
            finished <= 1'b0;
            if (launch) begin
                idx      <= '0;
                shape_q  <= shape_in;
                active   <= !any_zero(shape_in);
                finished <= any_zero(shape_in);
            end else if (active && advance) begin
                if (end_w && end_h && end_c && end_n) begin
                    active   <= 1'b0;
                    finished <= 1'b1;
                end else begin
                    idx <= idx_nx;
                end
            end
        end
    end

    // R2: column steps by one on a transfer that is not at the column end
    a_r2_col_step: assert property (@(posedge clk) disable iff (rst)
        active && advance && !end_w |=> idx.w == $past(idx.w) + DIM_ONE);

    // R2: column wrap carries into row
    a_r2_row_carry: assert property (@(posedge clk) disable iff (rst)
        active && advance && end_w && !end_h |=> idx.w == '0 && idx.h == $past(idx.h) + DIM_ONE);

    // R6: a stalled element keeps its indices
    a_r6_idx_hold: assert property (@(posedge clk) disable iff (rst)
        active && !advance && !launch |=> active && $stable(idx));

    // R7: finishing never overlaps an offered element
    a_r7_done_idle: assert property (@(posedge clk) disable iff (rst)
        finished |-> !active);

endmodule

// File: rtl/tlw_lane_map.sv
module tlw_lane_map
    import tlw_pkg::*;
#(
    parameter int unsigned LANES = 64,
    localparam int unsigned LANE_LOG = $clog2(LANES),
    localparam int unsigned POS_W = DIM_W + 1
) (
    input  logic [LANE_LOG-1:0] first_lane,
    input  dim_t                chan,
    input  dim_t                chan_cnt,
    output logic [LANE_LOG-1:0] lane,
    output logic [POS_W-1:0]    slot,
    output logic [POS_W-1:0]    slots_per_lane
);

    logic [POS_W-1:0] pos;
    logic [POS_W+LANE_LOG-1:0] span;

    always_comb begin
        pos  = POS_W'(first_lane) + POS_W'(chan);
        lane = pos[LANE_LOG-1:0];
        slot = pos >> LANE_LOG;
        span = (POS_W+LANE_LOG)'(first_lane) + (POS_W+LANE_LOG)'(chan_cnt)
             + (POS_W+LANE_LOG)'(LANES - 1);
        slots_per_lane = POS_W'(span >> LANE_LOG);
    end

endmodule

// File: rtl/tlw_addr_calc.sv
module tlw_addr_calc
    import tlw_pkg::*;
#(
    parameter int unsigned LANE_BYTES = 262144,
    parameter int unsigned SLOT_W = DIM_W + 1,
    localparam int unsigned LADDR_W = $clog2(LANE_BYTES),
    localparam int unsigned ELEM_W = SLOT_W + STR_W + 2,
    localparam int unsigned FULL_W = ELEM_W + 3 > LADDR_W + 1 ? ELEM_W + 3 : LADDR_W + 1,
    localparam int unsigned LIN_W = 4 * DIM_W,
    localparam int unsigned GADDR_W = LIN_W + 2
) (
    input  idx_t               idx,
    input  idx_t               shape,
    input  stride_t            str,
    input  logic [SLOT_W-1:0]  slot,
    input  logic [LADDR_W-1:0] base,
    input  esz_e               esz,
    output logic [LADDR_W-1:0] laddr,
    output logic [GADDR_W-1:0] gaddr,
    output logic               over
);

    logic [ELEM_W-1:0] elem;
    logic [FULL_W-1:0] full;
    logic [LIN_W-1:0]  lin;
    logic [1:0]        sh;

    always_comb begin
        sh   = esz_shift(esz);
        elem = ELEM_W'(idx.n) * ELEM_W'(str.n)
             + ELEM_W'(slot)  * ELEM_W'(str.c)
             + ELEM_W'(idx.h) * ELEM_W'(str.h)
             + ELEM_W'(idx.w) * ELEM_W'(str.w);
        full  = (FULL_W'(elem) << sh) + FULL_W'(base);
        over  = full >= FULL_W'(LANE_BYTES);
        laddr = full[LADDR_W-1:0];
        lin   = LIN_W'(idx.n) * LIN_W'(shape.c) + LIN_W'(idx.c);
        lin   = lin * LIN_W'(shape.h) + LIN_W'(idx.h);
        lin   = lin * LIN_W'(shape.w) + LIN_W'(idx.w);
        gaddr = GADDR_W'(lin) << sh;
    end

endmodule

// File: rtl/tensor_lane_walker.sv
module tensor_lane_walker
    import tlw_pkg::*;
#(
    parameter int unsigned LANES = 64,
    parameter int unsigned LANE_BYTES = 262144,
    localparam int unsigned LANE_LOG = $clog2(LANES),
    localparam int unsigned LADDR_W = $clog2(LANE_BYTES),
    localparam int unsigned GADDR_W = 4 * DIM_W + 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [DIM_W-1:0]    shp_n,
    input  logic [DIM_W-1:0]    shp_c,
    input  logic [DIM_W-1:0]    shp_h,
    input  logic [DIM_W-1:0]    shp_w,
    input  logic [LANE_LOG-1:0] start_lane,
    input  logic [STR_W-1:0]    str_n,
    input  logic [STR_W-1:0]    str_c,
    input  logic [STR_W-1:0]    str_h,
    input  logic [STR_W-1:0]    str_w,
    input  logic [1:0]          elem_size,
    input  logic [LADDR_W-1:0]  base_ofs,
    input  logic                out_ready,
    output logic                out_valid,
    output logic [LANE_LOG-1:0] out_lane,
    output logic [LADDR_W-1:0]  out_laddr,
    output logic [GADDR_W-1:0]  out_gaddr,
    output logic [DIM_W-1:0]    out_n,
    output logic [DIM_W-1:0]    out_c,
    output logic [DIM_W-1:0]    out_h,
    output logic [DIM_W-1:0]    out_w,
    output logic [DIM_W:0]      chans_per_lane,
    output logic                busy,
    output logic                done,
    output logic                ovf_err
);

    idx_t    shape_in, idx, shape_q;
    stride_t str_q;
    esz_e    esz_q;
    logic [LADDR_W-1:0]  base_q;
    logic [LANE_LOG-1:0] first_q;
    logic [DIM_W:0]      slot;
    logic active, finished, launch, fire, addr_over;

    assign shape_in = '{n: shp_n, c: shp_c, h: shp_h, w: shp_w};
    assign launch   = start && !active;
    assign fire     = active && out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            str_q   <= '0;
            esz_q   <= ESZ_BYTE;
            base_q  <= '0;
            first_q <= '0;
            ovf_err <= 1'b0;
        end else if (launch) begin
            str_q   <= '{n: str_n, c: str_c, h: str_h, w: str_w};
            esz_q   <= esz_e'(elem_size);
            base_q  <= base_ofs;
            first_q <= start_lane;
            ovf_err <= 1'b0;
        end else if (fire && addr_over) begin
            ovf_err <= 1'b1;
        end
    end

    tlw_walker u_walk (
        .clk      (clk),
        .rst      (rst),
        .launch   (launch),
        .advance  (out_ready),
        .shape_in (shape_in),
        .idx      (idx),
        .shape_q  (shape_q),
        .active   (active),
        .finished (finished)
    );

    tlw_lane_map #(.LANES(LANES)) u_map (
        .first_lane     (first_q),
        .chan           (idx.c),
        .chan_cnt       (shape_q.c),
        .lane           (out_lane),
        .slot           (slot),
        .slots_per_lane (chans_per_lane)
    );

    tlw_addr_calc #(.LANE_BYTES(LANE_BYTES), .SLOT_W(DIM_W + 1)) u_addr (
        .idx   (idx),
        .shape (shape_q),
        .str   (str_q),
        .slot  (slot),
        .base  (base_q),
        .esz   (esz_q),
        .laddr (out_laddr),
        .gaddr (out_gaddr),
        .over  (addr_over)
    );

    assign out_valid = active;
    assign busy      = active;
    assign done      = finished;
    assign out_n     = idx.n;
    assign out_c     = idx.c;
    assign out_h     = idx.h;
    assign out_w     = idx.w;

    // R9: the overflow flag persists until a new walk is accepted
    a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
        ovf_err && !launch |=> ovf_err);

    // R9: an out-of-slice transfer raises the flag
    a_r9_raise: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && addr_over |=> ovf_err);

    // R6: stalled outputs hold
    a_r6_out_hold: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_laddr) && $stable(out_lane)
                                   && $stable(out_gaddr));

    // R8: an empty shape completes at once with nothing offered
    a_r8_empty: assert property (@(posedge clk) disable iff (rst)
        launch && any_zero(shape_in) |=> done && !out_valid);

    // R11: a start during a walk leaves the lane split unchanged
    a_r11_ignore: assert property (@(posedge clk) disable iff (rst)
        busy && start |=> $stable(chans_per_lane));

endmodule

// File: tb/tensor_lane_walker_tb.sv
module tensor_lane_walker_tb;

    localparam int CLK_P = 10;
    localparam int LANE_BYTES = 262144;

    typedef struct packed {
        logic [7:0]  n, c, h, w;
        logic [5:0]  q;
        logic [15:0] sn, sc, sh, sw;
        logic [1:0]  esz;
        logic [17:0] base;
        logic [1:0]  rmode;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{8'd2, 8'd3,  8'd2, 8'd2, 6'd0,  16'd4,  16'd4, 16'd2,     16'd1,     2'd0, 18'd0,   2'd0},
        '{8'd1, 8'd66, 8'd1, 8'd2, 6'd63, 16'd8,  16'd4, 16'd2,     16'd1,     2'd1, 18'd128, 2'd1},
        '{8'd2, 8'd2,  8'd3, 8'd2, 6'd5,  16'd24, 16'd8, 16'd4,     16'd1,     2'd2, 18'd64,  2'd2},
        '{8'd1, 8'd1,  8'd2, 8'd2, 6'd10, 16'd0,  16'd0, 16'd65535, 16'd16384, 2'd3, 18'd0,   2'd0},
        '{8'd3, 8'd0,  8'd2, 8'd2, 6'd5,  16'd1,  16'd1, 16'd1,     16'd1,     2'd0, 18'd0,   2'd0}
    };

    logic clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic [7:0] shp_n = '0, shp_c = '0, shp_h = '0, shp_w = '0;
    logic [5:0] start_lane = '0;
    logic [15:0] str_n = '0, str_c = '0, str_h = '0, str_w = '0;
    logic [1:0] elem_size = '0;
    logic [17:0] base_ofs = '0;
    logic out_ready = 1'b0;
    logic out_valid, busy, done, ovf_err;
    logic [5:0] out_lane;
    logic [17:0] out_laddr;
    logic [33:0] out_gaddr;
    logic [7:0] out_n, out_c, out_h, out_w;
    logic [8:0] chans_per_lane;

    int checks = 0, fails = 0, cycles = 0;

    tensor_lane_walker u_dut (
        .clk(clk), .rst(rst), .start(start),
        .shp_n(shp_n), .shp_c(shp_c), .shp_h(shp_h), .shp_w(shp_w),
        .start_lane(start_lane),
        .str_n(str_n), .str_c(str_c), .str_h(str_h), .str_w(str_w),
        .elem_size(elem_size), .base_ofs(base_ofs), .out_ready(out_ready),
        .out_valid(out_valid), .out_lane(out_lane), .out_laddr(out_laddr),
        .out_gaddr(out_gaddr), .out_n(out_n), .out_c(out_c), .out_h(out_h),
        .out_w(out_w), .chans_per_lane(chans_per_lane), .busy(busy),
        .done(done), .ovf_err(ovf_err)
    );

    always #(CLK_P/2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++; checks++;
            $display("FAIL watchdog R7: actual cycles=%0d expected below 100000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v, input bit inject);
        int en = 0, ec = 0, eh = 0, ew = 0, k = 0, cyc = 0, total, shf, slot, step = 0;
        longint full, lin;
        bit eovf = 0, seen_done = 0, stall = 0, inj_on = 0, inj_chk = 0;
        logic [17:0] hold_la;
        logic [7:0]  hold_w;
        shf = (v.esz == 2'd0) ? 0 : (v.esz == 2'd1) ? 1 : 2;
        total = int'(v.n) * int'(v.c) * int'(v.h) * int'(v.w);
        @(negedge clk);
        shp_n = v.n; shp_c = v.c; shp_h = v.h; shp_w = v.w; start_lane = v.q;
        str_n = v.sn; str_c = v.sc; str_h = v.sh; str_w = v.sw;
        elem_size = v.esz; base_ofs = v.base; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R10 chans_per_lane", chans_per_lane, (int'(v.q) + int'(v.c) + 63) / 64);
        if (total == 0) begin
            chk("R8 done after empty start", done, 1);
            chk("R8 no element offered", out_valid, 0);
            chk("R9 flag cleared by start", ovf_err, 0);
            return;
        end
        while (!seen_done && cyc < 5000) begin
            step++;
            case (v.rmode)
                2'd1: out_ready = step[0];
                2'd2: out_ready = (step % 3) != 0;
                default: out_ready = 1'b1;
            endcase
            if (inject && k == 3 && !inj_on) begin
                start = 1'b1; shp_c = 8'd0; inj_on = 1;
            end else begin
                start = 1'b0;
            end
            #1;
            if (inj_on && !inj_chk && !start) begin
                inj_chk = 1;
                chk("R11 start while busy ignored", {busy, out_valid, done}, 3'b110);
            end
            if (stall) begin
                chk("R6 laddr held in stall", out_laddr, hold_la);
                chk("R6 index held in stall", out_w, hold_w);
            end
            stall = 0;
            if (done) begin
                seen_done = 1;
                chk("R7 no valid with done", out_valid, 0);
            end else if (out_valid) begin
                slot = (int'(v.q) + ec) / 64;
                full = longint'(v.base) + ((longint'(en) * v.sn + longint'(slot) * v.sc
                       + longint'(eh) * v.sh + longint'(ew) * v.sw) << shf);
                if (full >= LANE_BYTES) eovf = 1;
                lin = ((longint'(en) * v.c + ec) * v.h + eh) * v.w + ew;
                if (out_ready) begin
                    chk("R2 order n", out_n, en);
                    chk("R2 order c", out_c, ec);
                    chk("R2 order h", out_h, eh);
                    chk("R2 order w", out_w, ew);
                    chk("R3 lane", out_lane, (int'(v.q) + ec) % 64);
                    chk("R4 lane address", out_laddr, full % LANE_BYTES);
                    chk("R5 global address", out_gaddr, lin << shf);
                    k++;
                    ew++;
                    if (ew == int'(v.w)) begin ew = 0; eh++; end
                    if (eh == int'(v.h)) begin eh = 0; ec++; end
                    if (ec == int'(v.c)) begin ec = 0; en++; end
                end else begin
                    stall = 1; hold_la = out_laddr; hold_w = out_w;
                end
            end
            @(negedge clk);
            cyc++;
        end
        out_ready = 1'b0;
        chk("R7 done seen", seen_done, 1);
        chk("R7 element count", k, total);
        chk("R7 done single pulse", done, 0);
        chk("R9 sticky overflow after walk", ovf_err, eovf);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R1 reset out_valid", out_valid, 0);
        chk("R1 reset done", done, 0);
        chk("R1 reset busy", busy, 0);
        chk("R1 reset ovf_err", ovf_err, 0);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 5; i++) begin
            run_vec(VECS[i], 1'b0);
        end
        run_vec(VECS[3], 1'b0);
        run_vec(VECS[0], 1'b1);
        run_vec(VECS[4], 1'b0);
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule